// File: doc/BRIEF.md
# Interleaved Multi-Line Fetch Aligner

This block is the fetch stage of a front end that delivers up to four 32-bit instructions per cycle. The instruction store is split into two banks by line parity: one bank holds the even-numbered 32-byte lines and the other holds the odd-numbered lines. Each line has eight instruction words. In every cycle the block requests the line that contains the fetch PC and the line after it. The two requests go to different banks, so both are read in parallel. The banks answer one clock edge later.

When the data returns, the block builds a selection mask for each of the two lines. It pulls the chosen words into a four-slot group in program order and registers that group. The group is cut at the first slot that the predictor marks as a taken branch, and that slot stays in the group. The next fetch PC is the predicted target when a taken branch ended the group. Otherwise it is the start PC advanced by four bytes per delivered slot. A stall input freezes the group and the fetch PC.

The predictor drives one taken bit per slot. It also drives the target for the current fetch PC, which the block shows on `cur_pc`.

Top module: `fetch_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block does two things: it clears `grp_valid` and loads the fetch PC with `RESET_PC`. During reset the bank addresses request the lines of `RESET_PC`, so the first group after reset returns correct data.
- R2: A line index is PC[31:5]. Line L lives in the bank chosen by L bit 0 (0 selects the even bank). A bank address is a line index shifted right by one. For the requested PC P, both lines index(P) and index(P)+1 are addressed. When index(P) is odd, the even bank therefore receives (index(P)+1)>>1.
- R3: When no predicted-taken bit is set, all four slots are valid. Slot k holds the instruction word at address `grp_pc`+4k.
- R4: When the word offset PC[4:2] is above 4, the slots past the end of the current line come from word 0 onward of the next line in the other bank. This holds for both orders: even line to odd line, and odd line to even line.
- R5: `pred_taken` bit k refers to slot k of the current fetch PC. If the lowest set bit is k, slots 0 to k are valid and slots above k are not. Taken bits above the lowest set bit have no effect.
- R6: The next fetch PC equals `pred_target` when any predicted-taken bit fell inside the group. Otherwise it equals the start PC plus 4 times the number of valid slots. This value appears on `grp_next_pc` with the group and on `cur_pc` after the same edge.
- R7: While `stall` is high at a clock edge, the group outputs and `cur_pc` keep their values, and the prediction inputs have no effect. The banks keep being addressed for `cur_pc`.
- R8: The valid bits of a group are contiguous from slot 0. Each slot that is not valid carries an all-zero instruction field.
- R9: Latency: the group for a PC appears on the `grp_*` outputs at the first edge on which `cur_pc` showed that PC and `stall` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Hold group and fetch PC for this cycle |
| pred_taken | input | FETCH_W | Per-slot predicted-taken bits for `cur_pc` |
| pred_target | input | ADDR_W | Predicted target of the first taken slot |
| even_addr | output | ADDR_W-log2(LINE_WORDS)-3 | Read address of the even-line bank |
| odd_addr | output | ADDR_W-log2(LINE_WORDS)-3 | Read address of the odd-line bank |
| even_data | input | LINE_WORDS*32 | Even-bank line, word j in bits [32j+31:32j], one edge after address |
| odd_data | input | LINE_WORDS*32 | Odd-bank line, same layout |
| grp_valid | output | FETCH_W | Per-slot valid bits of the registered group |
| grp_instr | output | FETCH_W*32 | Slot k in bits [32k+31:32k] |
| grp_pc | output | ADDR_W | Address of slot 0 |
| grp_next_pc | output | ADDR_W | Fetch PC that follows this group |
| cur_pc | output | ADDR_W | Fetch PC whose lines are being aligned now |

## Verification
The hardest case to reach from the ports is a start PC that is far from the sequential flow. Examples are an odd line near its end, where the even bank must read the following line, and a start at the last word of a line. The bench steers the fetch PC to any chosen address by marking slot 0 taken, with the wanted PC as the target. On the next cycle it applies the vector under test, so each table row begins exactly at its own start PC. Stalls are checked with a prediction on the inputs, so any leak of a prediction into the held state would show.

// File: rtl/fa_pkg.sv
// Package: shared constants and types for the fetch aligner.
// Assumes fixed 32-bit instructions, so each instruction takes 4 bytes.
package fa_pkg;
    localparam int INSTR_W         = 32;
    localparam int INSTR_BYTE_BITS = 2;

    // Selects one of the two interleaved line banks by line parity.
    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_sel_e;
endpackage

// File: rtl/fa_bank_route.sv
// Module: fa_bank_route
// Maps a requested line index onto the even and odd bank addresses, so that
// the line and its successor are read together. It also orders the two
// returned lines as (line of the current PC, following line).
// Assumes the bank data belongs to the line index that was requested on the
// previous edge, and that cur_bank is the parity of that line.
module fa_bank_route
    import fa_pkg::*;
#(
    parameter int LIDX_W     = 27,
    parameter int LINE_WORDS = 8
) (
    input  logic [LIDX_W-1:0]             req_lidx,
    input  logic                          cur_bank,
    input  logic [LINE_WORDS*INSTR_W-1:0] even_data,
    input  logic [LINE_WORDS*INSTR_W-1:0] odd_data,
    output logic [LIDX_W-2:0]             even_addr,
    output logic [LIDX_W-2:0]             odd_addr,
    output logic [LINE_WORDS*INSTR_W-1:0] first_line,
    output logic [LINE_WORDS*INSTR_W-1:0] second_line
);
    logic [LIDX_W-1:0] next_lidx;

    assign next_lidx = req_lidx + 1'b1;

    // Purpose: send the requested line and its successor to their banks.
    always_comb begin
        if (bank_sel_e'(req_lidx[0]) == BANK_EVEN) begin
            even_addr = req_lidx[LIDX_W-1:1];
            odd_addr  = req_lidx[LIDX_W-1:1];
        end else begin
            odd_addr  = req_lidx[LIDX_W-1:1];
            even_addr = next_lidx[LIDX_W-1:1];
        end
    end

    // Purpose: put the returned lines in program order.
    always_comb begin
        if (bank_sel_e'(cur_bank) == BANK_ODD) begin
            first_line  = odd_data;
            second_line = even_data;
        end else begin
            first_line  = even_data;
            second_line = odd_data;
        end
    end
endmodule

// File: rtl/fa_slot_mask.sv
// Module: fa_slot_mask
// Turns the per-slot taken bits into three things: the slot valid vector,
// the slot count, and a word-select mask for each of the two lines. It stops
// at the first taken slot and keeps that slot in the group.
// Assumes FETCH_W <= LINE_WORDS and LINE_WORDS a power of two, so that a
// group never reaches past the second line.
module fa_slot_mask #(
    parameter int FETCH_W    = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic [FETCH_W-1:0]                 taken,
    input  logic [$clog2(LINE_WORDS)-1:0]      offset,
    output logic [FETCH_W-1:0]                 slot_valid,
    output logic [$clog2(FETCH_W+1)-1:0]       slot_cnt,
    output logic                               cut_taken,
    output logic [LINE_WORDS-1:0]              mask_first,
    output logic [LINE_WORDS-1:0]              mask_second
);
    localparam int OFS_W = $clog2(LINE_WORDS);
    localparam int CNT_W = $clog2(FETCH_W+1);

    // Purpose: a slot is valid only while no earlier slot was predicted taken.
    always_comb begin
        logic stop;
        stop       = 1'b0;
        slot_valid = '0;
        for (int k = 0; k < FETCH_W; k++) begin
            slot_valid[k] = !stop;
            if (taken[k]) begin
                stop = 1'b1;
            end
        end
        cut_taken = stop;
    end

    // Purpose: count the delivered slots, which sets the sequential advance.
    always_comb begin
        slot_cnt = '0;
        for (int k = 0; k < FETCH_W; k++) begin
            slot_cnt = slot_cnt + CNT_W'(slot_valid[k]);
        end
    end

    // Purpose: mark the words that each line gives to the group.
    always_comb begin
        logic [OFS_W:0] pos;
        pos         = '0;
        mask_first  = '0;
        mask_second = '0;
        for (int k = 0; k < FETCH_W; k++) begin
            pos = {1'b0, offset} + (OFS_W+1)'(k);
            if (slot_valid[k]) begin
                if (pos[OFS_W]) begin
                    mask_second[pos[OFS_W-1:0]] = 1'b1;
                end else begin
                    mask_first[pos[OFS_W-1:0]] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fa_align.sv
// Module: fa_align
// Final alignment: for each output slot it picks the word at offset+k from
// whichever of the two masked lines holds it. It drives zero when neither
// mask selects that word.
// Assumes the masks come from fa_slot_mask for the same offset.
module fa_align
    import fa_pkg::*;
#(
    parameter int FETCH_W    = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic [LINE_WORDS*INSTR_W-1:0] first_line,
    input  logic [LINE_WORDS*INSTR_W-1:0] second_line,
    input  logic [LINE_WORDS-1:0]         mask_first,
    input  logic [LINE_WORDS-1:0]         mask_second,
    input  logic [$clog2(LINE_WORDS)-1:0] offset,
    output logic [FETCH_W*INSTR_W-1:0]    slot_instr
);
    localparam int OFS_W = $clog2(LINE_WORDS);

    for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
        logic [OFS_W:0]       pos;
        logic [INSTR_W-1:0]   word;

        assign pos = {1'b0, offset} + (OFS_W+1)'(k);

        // Purpose: select the masked word for slot k from the right line.
        always_comb begin
            if (!pos[OFS_W] && mask_first[pos[OFS_W-1:0]]) begin
                word = first_line[pos[OFS_W-1:0]*INSTR_W +: INSTR_W];
            end else if (pos[OFS_W] && mask_second[pos[OFS_W-1:0]]) begin
                word = second_line[pos[OFS_W-1:0]*INSTR_W +: INSTR_W];
            end else begin
                word = '0;
            end
        end

        assign slot_instr[k*INSTR_W +: INSTR_W] = word;
    end
endmodule

// File: rtl/fetch_aligner.sv
// Module: fetch_aligner (top)
// Fetch stage for a FETCH_W-wide front end with a two-bank, parity-interleaved
// line store. The module holds the fetch PC. It aligns the two lines that came
// back for that PC, cuts the group at the first predicted-taken slot,
// registers the group, and sends the banks the lines of the next fetch PC.
// Assumes synchronous banks (data one edge after address) and a predictor
// that answers for cur_pc in the same cycle.
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                FETCH_W    = 4,
    parameter int                LINE_WORDS = 8,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0,
    localparam int               OFS_W      = $clog2(LINE_WORDS),
    localparam int               LINE_LSB   = OFS_W + INSTR_BYTE_BITS,
    localparam int               LIDX_W     = ADDR_W - LINE_LSB,
    localparam int               BANK_AW    = LIDX_W - 1,
    localparam int               LINE_BITS  = LINE_WORDS * INSTR_W,
    localparam int               GRP_BITS   = FETCH_W * INSTR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall,
    input  logic [FETCH_W-1:0]   pred_taken,
    input  logic [ADDR_W-1:0]    pred_target,
    output logic [BANK_AW-1:0]   even_addr,
    output logic [BANK_AW-1:0]   odd_addr,
    input  logic [LINE_BITS-1:0] even_data,
    input  logic [LINE_BITS-1:0] odd_data,
    output logic [FETCH_W-1:0]   grp_valid,
    output logic [GRP_BITS-1:0]  grp_instr,
    output logic [ADDR_W-1:0]    grp_pc,
    output logic [ADDR_W-1:0]    grp_next_pc,
    output logic [ADDR_W-1:0]    cur_pc
);
    localparam int CNT_W = $clog2(FETCH_W+1);

    logic [ADDR_W-1:0]     pc_q;
    logic [ADDR_W-1:0]     next_pc;
    logic [LIDX_W-1:0]     req_lidx;
    logic [OFS_W-1:0]      offset;
    logic [FETCH_W-1:0]    slot_valid;
    logic [CNT_W-1:0]      slot_cnt;
    logic                  cut_taken;
    logic [LINE_WORDS-1:0] mask_first;
    logic [LINE_WORDS-1:0] mask_second;
    logic [LINE_BITS-1:0]  first_line;
    logic [LINE_BITS-1:0]  second_line;
    logic [GRP_BITS-1:0]   slot_instr;

    assign offset = pc_q[LINE_LSB-1:INSTR_BYTE_BITS];
    assign cur_pc = pc_q;

    fa_bank_route #(
        .LIDX_W     (LIDX_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_route (
        .req_lidx    (req_lidx),
        .cur_bank    (pc_q[LINE_LSB]),
        .even_data   (even_data),
        .odd_data    (odd_data),
        .even_addr   (even_addr),
        .odd_addr    (odd_addr),
        .first_line  (first_line),
        .second_line (second_line)
    );

    fa_slot_mask #(
        .FETCH_W    (FETCH_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_mask (
        .taken       (pred_taken),
        .offset      (offset),
        .slot_valid  (slot_valid),
        .slot_cnt    (slot_cnt),
        .cut_taken   (cut_taken),
        .mask_first  (mask_first),
        .mask_second (mask_second)
    );

    fa_align #(
        .FETCH_W    (FETCH_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_align (
        .first_line  (first_line),
        .second_line (second_line),
        .mask_first  (mask_first),
        .mask_second (mask_second),
        .offset      (offset),
        .slot_instr  (slot_instr)
    );

    // Purpose: redirect on a predicted-taken cut, else advance past the group.
    always_comb begin
        if (cut_taken) begin
            next_pc = pred_target;
        end else begin
            next_pc = pc_q + ADDR_W'({slot_cnt, INSTR_BYTE_BITS'(0)});
        end
    end

    // Purpose: pick the line the banks read this edge (reset, hold or advance).
    always_comb begin
        if (!rst_n) begin
            req_lidx = RESET_PC[ADDR_W-1:LINE_LSB];
        end else if (stall) begin
            req_lidx = pc_q[ADDR_W-1:LINE_LSB];
        end else begin
            req_lidx = next_pc[ADDR_W-1:LINE_LSB];
        end
    end

    // Purpose: fetch PC and output group registers, held while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= RESET_PC;
            grp_valid   <= '0;
            grp_instr   <= '0;
            grp_pc      <= RESET_PC;
            grp_next_pc <= RESET_PC;
        end else if (!stall) begin
            pc_q        <= next_pc;
            grp_valid   <= slot_valid;
            grp_instr   <= slot_instr;
            grp_pc      <= pc_q;
            grp_next_pc <= next_pc;
        end
    end
endmodule

// File: rtl/fa_chk.sv
// Module: fa_chk
// Property checker for fetch_aligner, attached by bind. It observes ports only.
module fa_chk #(
    parameter int ADDR_W  = 32,
    parameter int FETCH_W = 4,
    parameter int BANK_AW = 26
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall,
    input logic [FETCH_W-1:0] pred_taken,
    input logic [ADDR_W-1:0]  pred_target,
    input logic [BANK_AW-1:0] even_addr,
    input logic [BANK_AW-1:0] odd_addr,
    input logic [FETCH_W-1:0] grp_valid,
    input logic [ADDR_W-1:0]  cur_pc
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> grp_valid == '0);

    // R2
    bank_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (even_addr == odd_addr) || (even_addr == odd_addr + 1'b1));

    // R3
    seq_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && pred_taken == '0) |=>
        (grp_valid == {FETCH_W{1'b1}} &&
         cur_pc == $past(cur_pc) + ADDR_W'(FETCH_W * 4)));

    // R5
    taken_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && pred_taken[0]) |=>
        (grp_valid == FETCH_W'(1) && cur_pc == $past(pred_target)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(grp_valid) && $stable(cur_pc)));

    // R8
    packed_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_valid + 1'b1) & grp_valid) == '0);
endmodule

bind fetch_aligner fa_chk #(
    .ADDR_W  (ADDR_W),
    .FETCH_W (FETCH_W),
    .BANK_AW (BANK_AW)
) u_fa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .even_addr   (even_addr),
    .odd_addr    (odd_addr),
    .grp_valid   (grp_valid),
    .cur_pc      (cur_pc)
);

// File: tb/test_fetch_aligner.sv
// Bench for fetch_aligner: a vector table walked by one loop, then directed
// reset and stall cases. The banks are modelled here as synchronous reads
// whose word contents are computed from the word address.
module test_fetch_aligner;
    localparam int          ADDR_W     = 32;
    localparam int          FETCH_W    = 4;
    localparam int          LINE_WORDS = 8;
    localparam int          BANK_AW    = 26;
    localparam logic [31:0] RST_PC     = 32'h0000_00F4;

    typedef struct packed {
        logic [31:0] pc;
        logic [3:0]  taken;
        logic [31:0] tgt;
        int          cnt;
        logic [31:0] nxt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 4'b0000, 32'h0000_0000, 4, 32'h0000_0110},
        '{32'h0000_0118, 4'b0000, 32'h0000_0000, 4, 32'h0000_0128},
        '{32'h0000_013C, 4'b0000, 32'h0000_0000, 4, 32'h0000_014C},
        '{32'h0000_0200, 4'b0100, 32'h0000_0400, 3, 32'h0000_0400},
        '{32'h0000_021C, 4'b0010, 32'h0000_0080, 2, 32'h0000_0080},
        '{32'h0000_0300, 4'b1010, 32'h0000_3000, 2, 32'h0000_3000},
        '{32'h0000_03F8, 4'b1000, 32'h0000_1000, 4, 32'h0000_1000},
        '{32'h0000_0004, 4'b0001, 32'h0000_07F0, 1, 32'h0000_07F0},
        '{32'h0000_02E4, 4'b0000, 32'h0000_0000, 4, 32'h0000_02F4}
    };

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic                         stall = 1'b0;
    logic [FETCH_W-1:0]           pred_taken = '0;
    logic [ADDR_W-1:0]            pred_target = '0;
    logic [BANK_AW-1:0]           even_addr;
    logic [BANK_AW-1:0]           odd_addr;
    logic [LINE_WORDS*32-1:0]     even_data;
    logic [LINE_WORDS*32-1:0]     odd_data;
    logic [FETCH_W-1:0]           grp_valid;
    logic [FETCH_W*32-1:0]        grp_instr;
    logic [ADDR_W-1:0]            grp_pc;
    logic [ADDR_W-1:0]            grp_next_pc;
    logic [ADDR_W-1:0]            cur_pc;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fetch_aligner #(
        .ADDR_W     (ADDR_W),
        .FETCH_W    (FETCH_W),
        .LINE_WORDS (LINE_WORDS),
        .RESET_PC   (RST_PC)
    ) i_fetch_aligner (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .pred_taken  (pred_taken),
        .pred_target (pred_target),
        .even_addr   (even_addr),
        .odd_addr    (odd_addr),
        .even_data   (even_data),
        .odd_data    (odd_data),
        .grp_valid   (grp_valid),
        .grp_instr   (grp_instr),
        .grp_pc      (grp_pc),
        .grp_next_pc (grp_next_pc),
        .cur_pc      (cur_pc)
    );

    function automatic logic [31:0] word_at(input logic [31:0] pc);
        return pc ^ 32'hA5C3_0000;
    endfunction

    // Synchronous bank model: even bank holds lines 2a, odd bank lines 2a+1.
    always @(posedge clk) begin
        for (int j = 0; j < LINE_WORDS; j++) begin
            even_data[j*32 +: 32] <= word_at({even_addr, 1'b0, 3'(j), 2'b00});
            odd_data[j*32 +: 32]  <= word_at({odd_addr, 1'b1, 3'(j), 2'b00});
        end
    end

    task automatic check(input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected bank addresses for a requested PC (R2).
    task automatic check_addr(input string tag, input logic [31:0] pc);
        logic [26:0] l;
        logic [26:0] ln;
        l  = pc[31:5];
        ln = l + 1'b1;
        check({tag, " odd_addr"}, 128'(odd_addr), 128'(l[26:1]));
        if (l[0]) check({tag, " even_addr"}, 128'(even_addr), 128'(ln[26:1]));
        else      check({tag, " even_addr"}, 128'(even_addr), 128'(l[26:1]));
    endtask

    // Expected group for start pc, slot count and next PC (R3 R5 R6 R8).
    task automatic check_group(input string tag, input logic [31:0] pc,
                               input int cnt, input logic [31:0] nxt);
        logic [127:0] exp_i;
        exp_i = '0;
        for (int k = 0; k < cnt; k++) begin
            exp_i[k*32 +: 32] = word_at(pc + 32'(4*k));
        end
        check({tag, " grp_valid"}, 128'(grp_valid), 128'((1 << cnt) - 1));
        check({tag, " grp_instr"}, grp_instr, exp_i);
        check({tag, " grp_pc"}, 128'(grp_pc), 128'(pc));
        check({tag, " grp_next_pc R6"}, 128'(grp_next_pc), 128'(nxt));
        check({tag, " cur_pc R6"}, 128'(cur_pc), 128'(nxt));
    endtask

    // Steer to v.pc with a slot-0 taken redirect, then apply the vector.
    task automatic run_vec(input vec_t v);
        string tag;
        if (v.taken != 4'b0000)  tag = "R5";
        else if (v.pc[4:2] > 4)  tag = "R4";
        else                     tag = "R3";
        pred_taken  = 4'b0001;
        pred_target = v.pc;
        @(negedge clk);
        check("R6 redirect cur_pc", 128'(cur_pc), 128'(v.pc));
        pred_taken  = v.taken;
        pred_target = v.tgt;
        #1;
        check_addr("R2", v.nxt);
        @(negedge clk);
        check_group(tag, v.pc, v.cnt, v.nxt);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [3:0]   hv;
        logic [127:0] hi;
        logic [31:0]  hp;

        // R1: reset state, bank requests for RESET_PC (line 7 odd)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 grp_valid", 128'(grp_valid), 128'(0));
        check("R1 cur_pc", 128'(cur_pc), 128'(RST_PC));
        check_addr("R1 R2 reset", RST_PC);

        // R4 R9: first group after reset crosses odd line 7 into even line 8
        rst_n = 1'b1;
        @(negedge clk);
        check_group("R4 R9 post-reset", RST_PC, 4, RST_PC + 32'h10);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R7: stall holds the group and the PC, and ignores predictions
        pred_taken  = 4'b0001;
        pred_target = 32'h0000_0500;
        @(negedge clk);
        hv = grp_valid;
        hi = grp_instr;
        hp = grp_pc;
        stall      = 1'b1;
        pred_taken = 4'b0000;
        #1;
        check_addr("R7 R2 stall", 32'h0000_0500);
        @(negedge clk);
        check("R7 grp_valid", 128'(grp_valid), 128'(hv));
        check("R7 grp_instr", grp_instr, hi);
        check("R7 grp_pc", 128'(grp_pc), 128'(hp));
        check("R7 cur_pc", 128'(cur_pc), 128'(32'h0000_0500));
        pred_taken  = 4'b0001;
        pred_target = 32'h0000_7777;
        @(negedge clk);
        check("R7 cur_pc ignores pred", 128'(cur_pc), 128'(32'h0000_0500));
        check("R7 grp_valid ignores pred", 128'(grp_valid), 128'(hv));
        stall      = 1'b0;
        pred_taken = 4'b0000;
        @(negedge clk);
        check_group("R7 resume", 32'h0000_0500, 4, 32'h0000_0510);

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run grp_valid", 128'(grp_valid), 128'(0));
        check("R1 mid-run cur_pc", 128'(cur_pc), 128'(RST_PC));
        rst_n = 1'b1;
        @(negedge clk);
        check_group("R1 after second reset", RST_PC, 4, RST_PC + 32'h10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule